// File: doc/BRIEF.md
# Butterfly All-Reduce Summation Engine

This block adds up a power-of-two set of signed integers so that every lane, not just one root, ends up holding the total. Software or a neighbouring unit presents all lanes at once on a wide input bus and pulses `start`. The engine then runs one exchange step per clock. In each step every lane adds the value held by a partner lane. The partner sits a fixed distance away, counted cyclically. That distance begins at half the lane count and halves after every step. After log2(LANES) steps every lane holds the same sum, and the engine pulses `done` once.

All lanes read their operands from the registered values of the previous step and are written together at the next edge. Each step therefore acts as a barrier: no lane sees a partner value that was already changed in the same step. Sums wrap modulo 2^WIDTH.

The control is a three-state machine.
- IDLE accepts a start. This is the transition *accept*, IDLE to EXCHANGE, and it loads every lane.
- EXCHANGE runs the steps. When the last step is taken, the transition *last-step* leads to FINISH.
- FINISH shows `done` for one cycle. The transition *retire* then returns it to IDLE unconditionally.

Top module: `bfly_allreduce`

## Requirements
- R1: LANES is a power of two of at least 2. Lane i of the input and of the output occupies bits [i*WIDTH +: WIDTH] of `din` and `dout`.
- R2: A `start` sampled while both `busy` and `done` are low copies `din` into all lanes and raises `busy` in the next cycle, with `dout` equal to the loaded values.
- R3: `busy` stays high for exactly log2(LANES) consecutive cycles per accepted start.
- R4: Step s (s = 1 .. log2(LANES)) uses offset LANES >> s. Every lane i becomes lane i plus lane (i + offset) mod LANES, and all operands are taken from the values before the step.
- R5: `done` is high for exactly one cycle, the cycle right after the last step, and `busy` is low in that cycle.
- R6: When `done` is high, every lane of `dout` equals the sum of all loaded inputs modulo 2^WIDTH.
- R7: A `start` sampled while `busy` is high is ignored: no reload, and the step timing and results are unchanged.
- R8: A `start` sampled while `done` is high is ignored: the engine returns to idle with the results unchanged.
- R9: While idle, `dout` keeps its last value until the next accepted start.
- R10: After reset `busy` and `done` are low and every lane of `dout` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Pulse that requests loading `din` and running a reduction |
| din | input | LANES*WIDTH | Parallel input values, one WIDTH-bit field per lane |
| busy | output | 1 | High while exchange steps are running |
| done | output | 1 | One-cycle pulse when all lanes hold the total |
| dout | output | LANES*WIDTH | Current lane contents, one WIDTH-bit field per lane |

## Verification
The functions that can land in the same cycle are a new request arriving and a running reduction, either in the middle of its steps or on its completion cycle. The bench raises `start` with fresh, different `din` values in the first busy cycle in one kind of run, and exactly in the `done` cycle in another. It does this on instances with 2, 4 and 16 lanes. The collision is judged correct when every later cycle still shows the per-step values computed arithmetically from the original inputs, `busy` and `done` keep their expected timing, and the idle result never takes on the injected values.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EXCH   = 2'd1,
        ST_FINISH = 2'd2
    } bfly_state_e;

endpackage

// File: rtl/bfly_step_seq.sv
module bfly_step_seq
    import bfly_pkg::*;
#(
    parameter int STEPS = 4,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          load,
    output logic          step_en,
    output logic [CW-1:0] step_idx,
    output logic          busy,
    output logic          done
);

    localparam logic [CW-1:0] LAST_IDX = CW'(STEPS - 1);

    bfly_state_e state_q, state_d;
    logic [CW-1:0] idx_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic: accept, last-step, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_EXCH;
            ST_EXCH:   if (idx_q == LAST_IDX) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // step counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (load) begin
            idx_q <= '0;
        end else if (step_en) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        load    = 1'b0;
        step_en = 1'b0;
        busy    = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE:   load = start;
            ST_EXCH: begin
                step_en = 1'b1;
                busy    = 1'b1;
            end
            ST_FINISH: done = 1'b1;
            default:   ;
        endcase
    end

    assign step_idx = idx_q;

endmodule

// File: rtl/bfly_partner_mux.sv
module bfly_partner_mux #(
    parameter int LANES = 16,
    parameter int WIDTH = 16,
    parameter int LANE  = 0,
    parameter int STEPS = 4,
    parameter int CW    = 3
) (
    input  logic [WIDTH-1:0] vals [LANES],
    input  logic [CW-1:0]    step_idx,
    output logic [WIDTH-1:0] partner
);

    // step k uses offset LANES >> (k+1), partner index wraps cyclically
    always_comb begin
        partner = '0;
        for (int k = 0; k < STEPS; k++) begin
            if (step_idx == CW'(k)) begin
                partner = vals[(LANE + (LANES >> (k + 1))) % LANES];
            end
        end
    end

endmodule

// File: rtl/bfly_lane.sv
module bfly_lane #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step_en,
    input  logic [WIDTH-1:0] load_val,
    input  logic [WIDTH-1:0] partner,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (step_en) begin
            q <= q + partner;
        end
    end

endmodule

// File: rtl/bfly_allreduce.sv
module bfly_allreduce #(
    parameter int LANES = 16,
    parameter int WIDTH = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [LANES*WIDTH-1:0] din,
    output logic                   busy,
    output logic                   done,
    output logic [LANES*WIDTH-1:0] dout
);

    localparam int STEPS = $clog2(LANES);
    localparam int CW    = $clog2(STEPS + 1) + 1;

    logic          load;
    logic          step_en;
    logic [CW-1:0] step_idx;
    logic [WIDTH-1:0] lane_q [LANES];

    bfly_step_seq #(
        .STEPS (STEPS),
        .CW    (CW)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .load     (load),
        .step_en  (step_en),
        .step_idx (step_idx),
        .busy     (busy),
        .done     (done)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [WIDTH-1:0] partner;

        bfly_partner_mux #(
            .LANES (LANES),
            .WIDTH (WIDTH),
            .LANE  (i),
            .STEPS (STEPS),
            .CW    (CW)
        ) u_mux (
            .vals     (lane_q),
            .step_idx (step_idx),
            .partner  (partner)
        );

        bfly_lane #(
            .WIDTH (WIDTH)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load),
            .step_en  (step_en),
            .load_val (din[i*WIDTH +: WIDTH]),
            .partner  (partner),
            .q        (lane_q[i])
        );

        assign dout[i*WIDTH +: WIDTH] = lane_q[i];
    end

endmodule

// File: rtl/bfly_allreduce_chk.sv
module bfly_allreduce_chk #(
    parameter int LANES = 16,
    parameter int WIDTH = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic                   busy,
    input logic                   done,
    input logic [LANES*WIDTH-1:0] dout
);

    localparam int STEPS = $clog2(LANES);

    logic [7:0] run_len;
    logic       lanes_same;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (busy) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    always_comb begin
        lanes_same = 1'b1;
        for (int i = 1; i < LANES; i++) begin
            if (dout[i*WIDTH +: WIDTH] != dout[WIDTH-1:0]) lanes_same = 1'b0;
        end
    end

    // R3
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_len == 8'(STEPS));

    // R3
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_len < 8'(STEPS));

    // R5
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    // R6
    done_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> lanes_same);

    // R7
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && run_len != 8'(STEPS - 1)) |=> busy);

    // R8
    done_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (!busy && $stable(dout)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(dout));

endmodule

bind bfly_allreduce bfly_allreduce_chk #(
    .LANES (LANES),
    .WIDTH (WIDTH)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .dout  (dout)
);

// File: tb/bfly_allreduce_bench.sv
module bfly_allreduce_bench;

    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic st_a = 1'b0, st_b = 1'b0, st_c = 1'b0;
    logic [2*W-1:0]  din_a = '0, dout_a;
    logic [4*W-1:0]  din_b = '0, dout_b;
    logic [16*W-1:0] din_c = '0, dout_c;
    logic busy_a, busy_b, busy_c, done_a, done_b, done_c;

    bfly_allreduce #(.LANES(2), .WIDTH(W)) u_bfly_allreduce_l2 (
        .clk(clk), .rst_n(rst_n), .start(st_a), .din(din_a),
        .busy(busy_a), .done(done_a), .dout(dout_a));
    bfly_allreduce #(.LANES(4), .WIDTH(W)) u_bfly_allreduce_l4 (
        .clk(clk), .rst_n(rst_n), .start(st_b), .din(din_b),
        .busy(busy_b), .done(done_b), .dout(dout_b));
    bfly_allreduce #(.LANES(16), .WIDTH(W)) u_bfly_allreduce (
        .clk(clk), .rst_n(rst_n), .start(st_c), .din(din_c),
        .busy(busy_c), .done(done_c), .dout(dout_c));

    int n_chk = 0;
    int n_bad = 0;
    logic [W-1:0] ref_v [3][16];

    function automatic int lanes_of(int k);
        return (k == 0) ? 2 : (k == 1) ? 4 : 16;
    endfunction

    function automatic logic [16*W-1:0] out_of(int k);
        if (k == 0) return {{(14*W){1'b0}}, dout_a};
        if (k == 1) return {{(12*W){1'b0}}, dout_b};
        return dout_c;
    endfunction

    function automatic logic busy_of(int k);
        return (k == 0) ? busy_a : (k == 1) ? busy_b : busy_c;
    endfunction

    function automatic logic done_of(int k);
        return (k == 0) ? done_a : (k == 1) ? done_b : done_c;
    endfunction

    // expected lane value t cycles after the accepting edge (R4 arithmetic)
    function automatic logic [W-1:0] expect_lane(int k, int t, int lane);
        logic [W-1:0] v [16];
        logic [W-1:0] nv [16];
        int n = lanes_of(k);
        int b = $clog2(n);
        int steps = (t - 1 < b) ? t - 1 : b;
        for (int i = 0; i < 16; i++) v[i] = ref_v[k][i];
        for (int s = 1; s <= steps; s++) begin
            for (int i = 0; i < n; i++) nv[i] = v[i] + v[(i + (n >> s)) % n];
            for (int i = 0; i < n; i++) v[i] = nv[i];
        end
        return v[lane];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive_din(input int k, input bit noise);
        for (int i = 0; i < lanes_of(k); i++) begin
            logic [W-1:0] val;
            val = noise ? (ref_v[k][i] ^ W'(8'h5A + i)) : ref_v[k][i];
            if (k == 0) din_a[i*W +: W] = val;
            else if (k == 1) din_b[i*W +: W] = val;
            else din_c[i*W +: W] = val;
        end
    endtask

    task automatic set_start(input int k, input logic v);
        if (k == 0) st_a = v;
        else if (k == 1) st_b = v;
        else st_c = v;
    endtask

    // pattern: 0 random, 1 all 0xFF, 2 index+1, 3 alternating 0x80/0x7F
    // mode: 0 clean, 1 start while busy (R7), 2 start in done cycle (R8)
    task automatic run_op(input int pattern, input int mode);
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < 16; i++) begin
                case (pattern)
                    0: ref_v[k][i] = W'($urandom);
                    1: ref_v[k][i] = 8'hFF;
                    2: ref_v[k][i] = W'(i + 1);
                    default: ref_v[k][i] = (i % 2 == 0) ? 8'h80 : 8'h7F;
                endcase
            end
            drive_din(k, 1'b0);
            set_start(k, 1'b1);
        end
        @(negedge clk);
        for (int t = 1; t <= 7; t++) begin
            for (int k = 0; k < 3; k++) begin
                int n = lanes_of(k);
                int b = $clog2(n);
                logic [16*W-1:0] o = out_of(k);
                string tag;
                if (t == 1) tag = "R2";
                else if (t <= b + 1) tag = (t == b + 1) ? "R6" : "R4";
                else tag = (mode == 2) ? "R8" : "R9";
                if (mode == 1 && t <= b + 1) tag = "R7";
                for (int i = 0; i < n; i++) begin
                    logic [W-1:0] e = expect_lane(k, t, i);
                    check(o[i*W +: W] == e, tag, $sformatf("L%0d t%0d lane%0d", n, t, i),
                          int'(o[i*W +: W]), int'(e));
                end
                check(busy_of(k) == (t <= b), "R3", $sformatf("busy L%0d t%0d", n, t),
                      int'(busy_of(k)), int'(t <= b));
                check(done_of(k) == (t == b + 1), "R5", $sformatf("done L%0d t%0d", n, t),
                      int'(done_of(k)), int'(t == b + 1));
                if ((mode == 1 && t == 1) || (mode == 2 && t == b + 1)) begin
                    drive_din(k, 1'b1);
                    set_start(k, 1'b1);
                end else begin
                    set_start(k, 1'b0);
                end
            end
            @(negedge clk);
        end
        for (int k = 0; k < 3; k++) set_start(k, 1'b0);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        for (int k = 0; k < 3; k++) begin
            check(busy_of(k) == 1'b0, "R10", "busy in reset", int'(busy_of(k)), 0);
            check(done_of(k) == 1'b0, "R10", "done in reset", int'(done_of(k)), 0);
            check(out_of(k) == '0, "R10", "dout in reset", int'(out_of(k) != '0), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 3; k++)
            check(out_of(k) == '0, "R10", "dout after release", int'(out_of(k) != '0), 0);
        // R1 R2 R4 R6 lane mapping and arithmetic under several patterns
        for (int p = 1; p <= 3; p++) run_op(p, 0);
        for (int r = 0; r < 6; r++) run_op(0, 0);
        // R7 start while busy
        for (int r = 0; r < 4; r++) run_op(0, 1);
        run_op(1, 1);
        // R8 start in done cycle
        for (int r = 0; r < 4; r++) run_op(0, 2);
        run_op(3, 2);
        // back-to-back after collisions still correct
        run_op(2, 0);
        finish_run();
    end

endmodule